// File: doc/BRIEF.md
# Pause Frame Flow-Control Generator

This block is the transmit-side flow-control engine of an Ethernet MAC. Software programs a pause quanta value, a re-send slot code, a zero-quanta option and an enable bit, and can set a self-clearing start bit. In full-duplex operation the start bit makes the block ask the MAC transmitter for one pause control frame carrying the programmed quanta. In half-duplex operation the same bit raises a backpressure output instead. The block presents one frame request at a time and holds it until the transmitter returns a done pulse.

After a pause frame completes, an internal pause timer loads the advertised quanta and counts down once per `quantum_tick` pulse, which marks 512 bit times. The slot code sets a point a few quanta before expiry. When the timer reaches that point and the external flow-control request is still high, the block asks for a fresh pause frame on its own. When the request drops while a pause is still in effect and the zero-quanta option is on, the block asks for a pause frame with quanta 0. This releases the link partner early.

Top module: `pfc_flow_ctrl`

## Requirements
- R1: During and just after synchronous reset, `busy`, `pf_valid` and `backpressure` are 0.
- R2: A write (`cfg_wr`=1) with `cfg_start`=1, `cfg_enable`=1 and `full_duplex`=1 sets `busy` at the next edge. `pf_valid` rises one edge later, with `pf_quanta` equal to the written quanta, `pf_dst`=0x0180C2000001, `pf_type`=0x8808 and `pf_opcode`=0x0001. `busy` stays 1 until the edge that accepts `pf_done`, and then reads 0.
- R3: A write presented while `busy` is 1 is ignored entirely. Its quanta, slot and option fields do not take effect, and its start bit requests no frame.
- R4: At most one frame request is outstanding. `pf_valid` and `pf_quanta` hold steady until `pf_done` is sampled high.
- R5: When a pause frame completes, the timer loads its quanta and then decrements on each `quantum_tick`. Slot codes 0, 1, 2 and 3 give thresholds of 4, 28, 144 and 256. When a tick brings the timer down to the threshold while `fc_req` is 1, a new frame with the programmed quanta is requested, and `pf_valid` rises on the following edge.
- R6: No automatic re-send occurs if `fc_req` is 0 at the threshold, or if the programmed quanta is not greater than the threshold.
- R7: With `cfg_zq_en`=1, the first edge that samples `fc_req` low after it was high, while the timer is nonzero, queues a frame with quanta 0, and `pf_valid` rises on the next edge. With `cfg_zq_en`=0, no such frame is sent.
- R8: With `cfg_enable`=0, a start produces no frame and no backpressure, and `busy` clears one edge after it was set.
- R9: With `full_duplex`=0, a start produces no frame. `busy` clears and `backpressure` rises one edge after `busy` was set. `backpressure` falls at the first edge that samples `fc_req` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_start | input | 1 | Start bit in the write |
| cfg_enable | input | 1 | Flow-control enable in the write |
| cfg_zq_en | input | 1 | Zero-quanta option in the write |
| cfg_slot | input | 2 | Re-send slot code in the write |
| cfg_quanta | input | QW | Pause quanta in the write |
| full_duplex | input | 1 | 1 = pause frames, 0 = backpressure |
| fc_req | input | 1 | External flow-control request |
| quantum_tick | input | 1 | One pulse per 512 bit times |
| busy | output | 1 | Start bit readback, self-clearing |
| pf_valid | output | 1 | Pause frame request |
| pf_quanta | output | QW | Quanta for the requested frame |
| pf_dst | output | 48 | Destination address of the frame |
| pf_type | output | 16 | Length/type of the frame |
| pf_opcode | output | 16 | Control opcode of the frame |
| pf_done | input | 1 | Transmitter finished the requested frame |
| backpressure | output | 1 | Half-duplex backpressure request |

## Verification
The bench builds the block with the default 16-bit quanta width and drives `quantum_tick` on every cycle. This makes timer windows of up to about 300 ticks short enough to run in full many times over. Random quanta are drawn just above each slot threshold, so the automatic re-send point is measured for all four slot codes. Directed cases cover quanta equal to a threshold, writes presented while busy, zero-quanta release with the option on and off, the disabled case and the half-duplex case.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

    localparam logic [47:0] PFC_DST    = 48'h0180C2000001;
    localparam logic [15:0] PFC_ETYPE  = 16'h8808;
    localparam logic [15:0] PFC_OPCODE = 16'h0001;
    localparam int          THR_W      = 9;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_SW   = 2'd1,
        SRC_AUTO = 2'd2,
        SRC_ZERO = 2'd3
    } pfc_src_e;

    typedef struct packed {
        logic       enable;
        logic       zq_en;
        logic [1:0] slot;
    } pfc_ctl_t;

    // quanta remaining on the timer at which a re-send is considered
    function automatic logic [THR_W-1:0] slot_threshold(input logic [1:0] code);
        case (code)
            2'd0:    return 9'd4;
            2'd1:    return 9'd28;
            2'd2:    return 9'd144;
            default: return 9'd256;
        endcase
    endfunction

endpackage

// File: rtl/pfc_cfg_regs.sv
module pfc_cfg_regs
    import pfc_pkg::*;
#(
    parameter int QW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          wr_start,
    input  pfc_ctl_t      wr_ctl,
    input  logic [QW-1:0] wr_quanta,
    input  logic          full_duplex,
    input  logic          sw_done,
    output pfc_ctl_t      ctl,
    output logic [QW-1:0] quanta,
    output logic          busy,
    output logic          bp_start
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl    <= '0;
            quanta <= '0;
            busy   <= 1'b0;
        end else if (wr_en && !busy) begin
            ctl    <= wr_ctl;
            quanta <= wr_quanta;
            busy   <= wr_start;
        end else if (busy) begin
            if (!ctl.enable || !full_duplex)
                busy <= 1'b0;
            else if (sw_done)
                busy <= 1'b0;
        end
    end

    assign bp_start = busy && ctl.enable && !full_duplex;

    // R3: a write while busy leaves every field untouched
    a_r3_write_ignored_busy: assert property (@(posedge clk) disable iff (rst)
        (wr_en && busy) |=> ($stable(quanta) && $stable(ctl)));

endmodule

// File: rtl/pfc_pause_timer.sv
module pfc_pause_timer
    import pfc_pkg::*;
#(
    parameter int QW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [QW-1:0] load_val,
    input  logic          tick,
    input  logic [1:0]    slot,
    output logic          active,
    output logic          hit
);

    localparam logic [QW-1:0] ONE = QW'(1);

    logic [QW-1:0] cnt;
    logic [QW-1:0] thr_q;

    assign thr_q  = QW'(slot_threshold(slot));
    assign active = (cnt != '0);
    assign hit    = tick && !load && (cnt == thr_q + ONE);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (tick && active)
            cnt <= cnt - ONE;
    end

    // R5: without a load the timer only counts down
    a_r5_timer_no_rise: assert property (@(posedge clk) disable iff (rst)
        !load |=> (cnt <= $past(cnt)));

endmodule

// File: rtl/pfc_req_arb.sv
module pfc_req_arb
    import pfc_pkg::*;
#(
    parameter int QW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          fd,
    input  logic          zq_en,
    input  logic          sw_req,
    input  logic [QW-1:0] quanta,
    input  logic          hit,
    input  logic          fc_req,
    input  logic          timer_active,
    input  logic          done,
    output logic          valid,
    output logic [QW-1:0] out_quanta,
    output logic          sw_done,
    output logic          load
);

    pfc_src_e src;
    logic     fc_q;
    logic     auto_p;
    logic     zero_p;
    logic     fall;

    assign fall    = fc_q && !fc_req;
    assign load    = valid && done;
    assign sw_done = load && (src == SRC_SW);

    always_ff @(posedge clk) begin
        if (rst) begin
            fc_q       <= 1'b0;
            auto_p     <= 1'b0;
            zero_p     <= 1'b0;
            valid      <= 1'b0;
            out_quanta <= '0;
            src        <= SRC_NONE;
        end else begin
            fc_q <= fc_req;
            if (!en || !fd) begin
                auto_p <= 1'b0;
                zero_p <= 1'b0;
            end else begin
                if (hit && fc_req)
                    auto_p <= 1'b1;
                if (fall && zq_en && timer_active)
                    zero_p <= 1'b1;
            end
            if (valid) begin
                if (done) begin
                    valid <= 1'b0;
                    src   <= SRC_NONE;
                end
            end else if (en && fd) begin
                if (sw_req) begin
                    valid      <= 1'b1;
                    out_quanta <= quanta;
                    src        <= SRC_SW;
                end else if (auto_p) begin
                    valid      <= 1'b1;
                    out_quanta <= quanta;
                    src        <= SRC_AUTO;
                    auto_p     <= 1'b0;
                end else if (zero_p) begin
                    valid      <= 1'b1;
                    out_quanta <= '0;
                    src        <= SRC_ZERO;
                    zero_p     <= 1'b0;
                end
            end
        end
    end

    // R4: request held steady until accepted
    a_r4_hold_until_done: assert property (@(posedge clk) disable iff (rst)
        (valid && !done) |=> (valid && $stable(out_quanta) && $stable(src)));

    // R8: nothing is issued while disabled
    a_r8_disabled_no_issue: assert property (@(posedge clk) disable iff (rst)
        !en |=> !$rose(valid));

endmodule

// File: rtl/pfc_flow_ctrl.sv
module pfc_flow_ctrl
    import pfc_pkg::*;
#(
    parameter int QW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_wr,
    input  logic          cfg_start,
    input  logic          cfg_enable,
    input  logic          cfg_zq_en,
    input  logic [1:0]    cfg_slot,
    input  logic [QW-1:0] cfg_quanta,
    input  logic          full_duplex,
    input  logic          fc_req,
    input  logic          quantum_tick,
    output logic          busy,
    output logic          pf_valid,
    output logic [QW-1:0] pf_quanta,
    output logic [47:0]   pf_dst,
    output logic [15:0]   pf_type,
    output logic [15:0]   pf_opcode,
    input  logic          pf_done,
    output logic          backpressure
);

    pfc_ctl_t      wr_ctl;
    pfc_ctl_t      ctl;
    logic [QW-1:0] quanta;
    logic          bp_start;
    logic          bp_active;
    logic          sw_done;
    logic          load;
    logic          hit;
    logic          timer_active;

    assign wr_ctl = '{enable: cfg_enable, zq_en: cfg_zq_en, slot: cfg_slot};

    pfc_cfg_regs #(.QW(QW)) u_cfg (
        .clk(clk), .rst(rst), .wr_en(cfg_wr), .wr_start(cfg_start),
        .wr_ctl(wr_ctl), .wr_quanta(cfg_quanta), .full_duplex(full_duplex),
        .sw_done(sw_done), .ctl(ctl), .quanta(quanta), .busy(busy),
        .bp_start(bp_start)
    );

    pfc_pause_timer #(.QW(QW)) u_timer (
        .clk(clk), .rst(rst), .load(load), .load_val(pf_quanta),
        .tick(quantum_tick), .slot(ctl.slot), .active(timer_active), .hit(hit)
    );

    pfc_req_arb #(.QW(QW)) u_arb (
        .clk(clk), .rst(rst), .en(ctl.enable), .fd(full_duplex),
        .zq_en(ctl.zq_en), .sw_req(busy), .quanta(quanta), .hit(hit),
        .fc_req(fc_req), .timer_active(timer_active), .done(pf_done),
        .valid(pf_valid), .out_quanta(pf_quanta), .sw_done(sw_done), .load(load)
    );

    always_ff @(posedge clk) begin
        if (rst)
            bp_active <= 1'b0;
        else if (bp_start)
            bp_active <= 1'b1;
        else if (!fc_req)
            bp_active <= 1'b0;
    end

    assign backpressure = bp_active && ctl.enable && !full_duplex;
    assign pf_dst       = PFC_DST;
    assign pf_type      = PFC_ETYPE;
    assign pf_opcode    = PFC_OPCODE;

    // R2: busy clears once its own frame is accepted
    a_r2_busy_clears: assert property (@(posedge clk) disable iff (rst)
        sw_done |=> !busy);

    // R9: backpressure only starts from a half-duplex start
    a_r9_bp_from_start: assert property (@(posedge clk) disable iff (rst)
        $rose(bp_active) |-> $past(busy && !full_duplex));

endmodule

// File: tb/sim_pfc_flow_ctrl.sv
module sim_pfc_flow_ctrl;

    localparam int QW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_wr = 1'b0, cfg_start = 1'b0, cfg_enable = 1'b0, cfg_zq_en = 1'b0;
    logic [1:0]    cfg_slot = '0;
    logic [QW-1:0] cfg_quanta = '0;
    logic          full_duplex = 1'b1, fc_req = 1'b0, quantum_tick = 1'b1, pf_done = 1'b0;
    logic          busy, pf_valid, backpressure;
    logic [QW-1:0] pf_quanta;
    logic [47:0]   pf_dst;
    logic [15:0]   pf_type, pf_opcode;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    pfc_flow_ctrl #(.QW(QW)) u0 (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_start(cfg_start),
        .cfg_enable(cfg_enable), .cfg_zq_en(cfg_zq_en), .cfg_slot(cfg_slot),
        .cfg_quanta(cfg_quanta), .full_duplex(full_duplex), .fc_req(fc_req),
        .quantum_tick(quantum_tick), .busy(busy), .pf_valid(pf_valid),
        .pf_quanta(pf_quanta), .pf_dst(pf_dst), .pf_type(pf_type),
        .pf_opcode(pf_opcode), .pf_done(pf_done), .backpressure(backpressure)
    );

    function automatic int thr_of(input int code);
        case (code)
            0: return 4;
            1: return 28;
            2: return 144;
            default: return 256;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_cfg(input bit st, input bit en, input bit zq, input int slot, input int q);
        cfg_wr = 1'b1; cfg_start = st; cfg_enable = en; cfg_zq_en = zq;
        cfg_slot = 2'(slot); cfg_quanta = QW'(q);
        cyc();
        cfg_wr = 1'b0; cfg_start = 1'b0;
    endtask

    task automatic complete();
        pf_done = 1'b1;
        cyc();
        pf_done = 1'b0;
    endtask

    task automatic wait_valid(input int maxn, output int n);
        n = 0;
        while (!pf_valid && n < maxn) begin
            cyc();
            n++;
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        summary();
    end

    initial begin
        int n;
        int q;
        int s;
        void'($urandom(32'd1234));
        repeat (3) cyc();
        // R1 reset state
        chk(!busy && !pf_valid && !backpressure, "R1 reset outputs", {busy, pf_valid, backpressure}, 0);
        rst = 1'b0;
        cyc();
        chk(!busy && !pf_valid && !backpressure, "R1 after reset", {busy, pf_valid, backpressure}, 0);

        // R2 software start, full duplex
        write_cfg(1, 1, 0, 3, 100);
        chk(busy && !pf_valid, "R2 busy set, no frame yet", {busy, pf_valid}, 2'b10);
        cyc();
        chk(pf_valid, "R2 frame requested", pf_valid, 1);
        chk(pf_quanta == 100, "R2 quanta", pf_quanta, 100);
        chk(pf_dst == 48'h0180C2000001 && pf_type == 16'h8808 && pf_opcode == 16'h0001,
            "R2 frame header", pf_dst, 48'h0180C2000001);
        cyc();
        chk(busy && pf_valid && pf_quanta == 100, "R4 held while waiting", {busy, pf_valid}, 2'b11);
        complete();
        chk(!busy && !pf_valid, "R2 busy cleared after done", {busy, pf_valid}, 0);

        // R8 disabled
        write_cfg(1, 0, 0, 0, 50);
        chk(busy, "R8 busy set", busy, 1);
        cyc();
        chk(!busy, "R8 busy cleared", busy, 0);
        wait_valid(10, n);
        chk(n == 10 && !backpressure, "R8 no frame or backpressure", n, 10);

        // R9 half duplex
        full_duplex = 1'b0; fc_req = 1'b1;
        write_cfg(1, 1, 0, 0, 50);
        chk(busy && !backpressure, "R9 busy set", {busy, backpressure}, 2'b10);
        cyc();
        chk(!busy && backpressure, "R9 backpressure up", {busy, backpressure}, 2'b01);
        repeat (5) cyc();
        chk(backpressure && !pf_valid, "R9 held, no frame", {backpressure, pf_valid}, 2'b10);
        fc_req = 1'b0;
        cyc();
        chk(!backpressure, "R9 backpressure down", backpressure, 0);
        full_duplex = 1'b1;
        repeat (300) cyc();

        // R3 write while busy is ignored
        fc_req = 1'b1;
        write_cfg(1, 1, 0, 0, 50);
        cyc();
        chk(pf_valid && pf_quanta == 50, "R3 first frame", pf_quanta, 50);
        write_cfg(1, 1, 0, 3, 77);
        complete();
        chk(!busy, "R3 busy cleared", busy, 0);
        wait_valid(200, n);
        chk(n == 47, "R5 slot0 re-send timing", n, 47);
        chk(pf_quanta == 50, "R3 quanta kept from earlier write", pf_quanta, 50);
        complete();
        fc_req = 1'b0;
        repeat (60) cyc();

        // R6 quanta equal to threshold
        fc_req = 1'b1;
        write_cfg(1, 1, 0, 1, 28);
        cyc();
        complete();
        wait_valid(60, n);
        chk(n == 60, "R6 no re-send when quanta equals threshold", n, 60);
        fc_req = 1'b0;
        repeat (40) cyc();
        // R6 request low at threshold
        write_cfg(1, 1, 0, 0, 20);
        cyc();
        complete();
        wait_valid(40, n);
        chk(n == 40, "R6 no re-send with request low", n, 40);

        // R7 zero quanta on request release
        fc_req = 1'b1;
        write_cfg(1, 1, 1, 3, 100);
        cyc();
        complete();
        repeat (3) cyc();
        fc_req = 1'b0;
        cyc();
        chk(!pf_valid, "R7 not yet issued", pf_valid, 0);
        cyc();
        chk(pf_valid && pf_quanta == 0, "R7 zero-quanta frame", pf_quanta, 0);
        complete();
        fc_req = 1'b1;
        write_cfg(1, 1, 0, 3, 100);
        cyc();
        complete();
        repeat (3) cyc();
        fc_req = 1'b0;
        wait_valid(20, n);
        chk(n == 20, "R7 no zero frame with option off", n, 20);
        repeat (120) cyc();

        // R5 random quanta around every slot threshold
        for (int i = 0; i < 20; i++) begin
            s = int'($urandom_range(3, 0));
            q = thr_of(s) + 1 + int'($urandom_range(39, 0));
            fc_req = 1'b1;
            write_cfg(1, 1, 0, s, q);
            cyc();
            chk(pf_valid && pf_quanta == QW'(q), "R2 random start frame", pf_quanta, q);
            complete();
            wait_valid(400, n);
            chk(n == q - thr_of(s) + 1, "R5 random re-send timing", n, q - thr_of(s) + 1);
            chk(pf_quanta == QW'(q), "R5 random re-send quanta", pf_quanta, q);
            complete();
            fc_req = 1'b0;
            repeat (q + 5) cyc();
        end
        summary();
    end

endmodule